// File: doc/BRIEF.md
# I2C Serial EEPROM Target

This block is the target side of a two-wire serial bus that behaves like a small serial EEPROM. It samples the open-drain clock and data lines in the system clock domain. It pulls the data line low only through an output-enable, so the line itself stays external with a pull-up. Inside it holds a byte array of `MEM_BYTES` entries and one address pointer that both writes and reads share.

A bus master selects the block with a control byte. That byte carries a fixed device-type code and three select bits, which must match the `sel_i` pins. A write frame loads the pointer from its first data byte and then stores any number of bytes, so a single-byte write and a page write are the same frame. During a page write the pointer stays inside its `PAGE_BYTES` page. A read frame returns bytes from the pointer for as long as the master acknowledges them. It can follow a dummy write and a repeated start (random read), or it can simply continue from wherever the pointer was left (current-address read).

Top module: `eepr_i2c_target`

## Requirements
- R1: A control byte is accepted when bits [7:4] equal 4'b1010 and bits [3:1] equal `sel_i`. Bit 0 selects the direction, 1 meaning read. The block acknowledges an accepted control byte by holding SDA low through the ninth clock.
- R2: For a control byte that does not match, the block leaves SDA released. It also ignores every later bit until the next start, so memory and pointer stay unchanged.
- R3: After a write control byte, the first byte loads the address pointer and is acknowledged. An address byte of `MEM_BYTES` or more is not acknowledged, and the rest of that frame is ignored.
- R4: Each later byte of a write frame is acknowledged and stored at the pointer. The pointer then advances within its page: the low log2(`PAGE_BYTES`) bits wrap and the upper bits stay fixed.
- R5: Each byte sent in a read is the byte at the pointer. The pointer then advances by one and wraps from `MEM_BYTES`-1 to 0. A read frame with no preceding address starts at the pointer left by the previous frame.
- R6: A write control byte, then an address byte, then a repeated start and a read control byte returns data starting at that address.
- R7: The block sends the next byte while the master acknowledges. After a master NACK it keeps SDA released on every clock until the next start or stop.
- R8: The block changes its SDA drive only while SCL is low. It keeps SDA released during the master's acknowledge slot.
- R9: A start condition at any point aborts the current byte, releases SDA and expects a new control byte. A stop releases SDA.
- R10: While and after reset, SDA is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_i | input | 3 | Select pins compared with control byte bits [3:1] |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
The bench runs a page write that starts three bytes before a page end. A design that carries into the next page would leave the first bytes of the page unchanged and overwrite the next page. A read starting two bytes before the end of memory checks the wrap to address 0. A design that saturates there, or that runs past the array, returns the wrong bytes. Frames with a wrong device code, wrong select bits or an out-of-range address are followed by data bytes and then a read-back: a block that ignores too little would acknowledge them or change memory. A repeated start is issued mid-byte, and extra clocks are sent after a master NACK. A design that kept its bit count or kept driving SDA would return a different byte or pull the line low.

// File: rtl/eepr_pkg.sv
package eepr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,  // released, waiting for start
    ST_RX,    // shifting in a byte from the master
    ST_ACK,   // holding SDA low for the ninth clock
    ST_TX,    // shifting a byte out to the master
    ST_MACK   // master's acknowledge slot after a sent byte
  } phase_t;

  typedef enum logic [1:0] {
    RX_CTRL,
    RX_ADDR,
    RX_DATA
  } rxkind_t;

  localparam logic [3:0] DEV_TYPE = 4'b1010;

  // control byte match: type code in the top nibble, select bits below it
  function automatic logic ctrl_hit(input logic [7:0] b, input logic [2:0] sel);
    return (b[7:4] == DEV_TYPE) && (b[3:1] == sel);
  endfunction

  // pointer step for reads: wraps at the end of the array
  function automatic logic [7:0] linear_next(input logic [7:0] p, input int depth);
    int n;
    n = (int'(p) + 1) % depth;
    return n[7:0];
  endfunction

  // pointer step for writes: wraps inside the page holding p
  function automatic logic [7:0] page_next(input logic [7:0] p, input int pg);
    int base;
    int off;
    int r;
    base = (int'(p) / pg) * pg;
    off  = ((int'(p) % pg) + 1) % pg;
    r    = base + off;
    return r[7:0];
  endfunction

endpackage

// File: rtl/eepr_line_sync.sv
module eepr_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_q,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);

  logic [SYNC_STAGES-1:0] scl_s;
  logic [SYNC_STAGES-1:0] sda_s;
  logic                   scl_p;
  logic                   sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s <= '1;
      sda_s <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_s <= {scl_s[SYNC_STAGES-2:0], scl_i};
      sda_s <= {sda_s[SYNC_STAGES-2:0], sda_i};
      scl_p <= scl_s[SYNC_STAGES-1];
      sda_p <= sda_s[SYNC_STAGES-1];
    end
  end

  assign scl_q    = scl_s[SYNC_STAGES-1];
  assign sda_q    = sda_s[SYNC_STAGES-1];
  assign scl_rise = scl_q & ~scl_p;
  assign scl_fall = ~scl_q & scl_p;
  // data edges with the clock held high mark start and stop
  assign start_ev = scl_q & scl_p & sda_p & ~sda_q;
  assign stop_ev  = scl_q & scl_p & ~sda_p & sda_q;

endmodule

// File: rtl/eepr_byte_store.sv
module eepr_byte_store #(
  parameter int DEPTH = 128,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];

endmodule

// File: rtl/eepr_i2c_target.sv
module eepr_i2c_target
  import eepr_pkg::*;
#(
  parameter int MEM_BYTES   = 128,
  parameter int PAGE_BYTES  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel_i,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe
);

  localparam int ADDR_W = $clog2(MEM_BYTES);

  // bus events
  logic scl_q, sda_q, scl_rise, scl_fall, start_ev, stop_ev;

  eepr_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_q    (scl_q),
    .sda_q    (sda_q),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  phase_t            phase;
  rxkind_t           kind;
  logic              rw_read;
  logic [3:0]        bit_cnt;
  logic [7:0]        rx_sh;
  logic [7:0]        tx_sh;
  logic [ADDR_W-1:0] ptr;
  logic              oe_q;
  logic              mack_ok;
  logic [7:0]        rd_data;

  // named internal events, also used by the checker
  logic byte_done, ctrl_ok, addr_ok, accept;
  logic ev_ctrl_nack, ev_addr_nack, ev_wr, ev_rd_load, in_mack;
  logic [ADDR_W-1:0] ptr_page_next, ptr_lin_next;

  assign byte_done     = scl_fall && (phase == ST_RX) && (bit_cnt == 4'd8);
  assign ctrl_ok       = ctrl_hit(rx_sh, sel_i);
  assign addr_ok       = ({24'd0, rx_sh} < 32'(MEM_BYTES));
  assign accept        = (kind == RX_CTRL) ? ctrl_ok :
                         (kind == RX_ADDR) ? addr_ok : 1'b1;
  assign ev_ctrl_nack  = byte_done && (kind == RX_CTRL) && !ctrl_ok;
  assign ev_addr_nack  = byte_done && (kind == RX_ADDR) && !addr_ok;
  assign ev_wr         = byte_done && (kind == RX_DATA);
  assign ev_rd_load    = scl_fall && (((phase == ST_ACK) && rw_read) ||
                                      ((phase == ST_MACK) && mack_ok));
  assign in_mack       = (phase == ST_MACK);
  assign ptr_page_next = ADDR_W'(page_next(8'(ptr), PAGE_BYTES));
  assign ptr_lin_next  = ADDR_W'(linear_next(8'(ptr), MEM_BYTES));

  eepr_byte_store #(.DEPTH(MEM_BYTES)) u_store (
    .clk   (clk),
    .we    (ev_wr),
    .waddr (ptr),
    .wdata (rx_sh),
    .raddr (ptr),
    .rdata (rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= ST_IDLE;
      kind    <= RX_CTRL;
      rw_read <= 1'b0;
      bit_cnt <= 4'd0;
      rx_sh   <= 8'd0;
      tx_sh   <= 8'd0;
      ptr     <= '0;
      oe_q    <= 1'b0;
      mack_ok <= 1'b0;
    end else if (start_ev) begin
      phase   <= ST_RX;
      kind    <= RX_CTRL;
      rw_read <= 1'b0;
      bit_cnt <= 4'd0;
      oe_q    <= 1'b0;
    end else if (stop_ev) begin
      phase <= ST_IDLE;
      oe_q  <= 1'b0;
    end else begin
      case (phase)
        ST_RX: begin
          if (scl_rise && (bit_cnt < 4'd8)) begin
            rx_sh   <= {rx_sh[6:0], sda_q};
            bit_cnt <= bit_cnt + 4'd1;
          end else if (byte_done) begin
            if (accept) begin
              oe_q  <= 1'b1;
              phase <= ST_ACK;
              case (kind)
                RX_CTRL: begin
                  rw_read <= rx_sh[0];
                  kind    <= RX_ADDR;
                end
                RX_ADDR: begin
                  ptr  <= rx_sh[ADDR_W-1:0];
                  kind <= RX_DATA;
                end
                default: ptr <= ptr_page_next;
              endcase
            end else begin
              phase <= ST_IDLE;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            bit_cnt <= 4'd0;
            if (rw_read) begin
              tx_sh <= rd_data;
              oe_q  <= ~rd_data[7];
              ptr   <= ptr_lin_next;
              phase <= ST_TX;
            end else begin
              oe_q  <= 1'b0;
              phase <= ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bit_cnt == 4'd7) begin
              oe_q  <= 1'b0;
              phase <= ST_MACK;
            end else begin
              bit_cnt <= bit_cnt + 4'd1;
              tx_sh   <= {tx_sh[6:0], 1'b0};
              oe_q    <= ~tx_sh[6];
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) mack_ok <= ~sda_q;
          if (scl_fall) begin
            bit_cnt <= 4'd0;
            if (mack_ok) begin
              tx_sh <= rd_data;
              oe_q  <= ~rd_data[7];
              ptr   <= ptr_lin_next;
              phase <= ST_TX;
            end else begin
              phase <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe = oe_q;

endmodule

// File: rtl/eepr_i2c_checker.sv
module eepr_i2c_checker #(
  parameter int MEM_BYTES  = 128,
  parameter int PAGE_BYTES = 16,
  localparam int ADDR_W    = $clog2(MEM_BYTES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_q,
  input logic              start_ev,
  input logic              stop_ev,
  input logic              sda_oe,
  input logic              in_mack,
  input logic              ev_ctrl_nack,
  input logic              ev_addr_nack,
  input logic              ev_wr,
  input logic              ev_rd_load,
  input logic [ADDR_W-1:0] ptr
);

  assert_drive_scl_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !$past(scl_q));

  assert_mack_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_mack |-> !sda_oe);

  assert_start_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> !sda_oe);

  assert_stop_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_oe);

  assert_ctrl_nack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ctrl_nack |=> !sda_oe);

  assert_addr_nack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_addr_nack |=> !sda_oe);

  assert_page_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr |=> (ptr == ADDR_W'(eepr_pkg::page_next(8'($past(ptr)), PAGE_BYTES))));

  assert_read_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rd_load |=> (ptr == ADDR_W'(eepr_pkg::linear_next(8'($past(ptr)), MEM_BYTES))));

endmodule

bind eepr_i2c_target eepr_i2c_checker #(
  .MEM_BYTES  (MEM_BYTES),
  .PAGE_BYTES (PAGE_BYTES)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .scl_q        (scl_q),
  .start_ev     (start_ev),
  .stop_ev      (stop_ev),
  .sda_oe       (sda_oe),
  .in_mack      (in_mack),
  .ev_ctrl_nack (ev_ctrl_nack),
  .ev_addr_nack (ev_addr_nack),
  .ev_wr        (ev_wr),
  .ev_rd_load   (ev_rd_load),
  .ptr          (ptr)
);

// File: tb/eepr_i2c_target_bench.sv
module eepr_i2c_target_bench;

  localparam int MEM  = 128;
  localparam int PAGE = 16;
  localparam int Q    = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic [2:0] sel = 3'b101;
  logic       sda_oe;
  wire        sda_line = sda_m & ~sda_oe;

  always #5 clk = ~clk;

  eepr_i2c_target #(.MEM_BYTES(MEM), .PAGE_BYTES(PAGE)) u_eepr_i2c_target (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel_i  (sel),
    .scl_i  (scl_m),
    .sda_i  (sda_line),
    .sda_oe (sda_oe)
  );

  int         checks = 0;
  int         fails  = 0;
  logic [7:0] model [MEM];
  int         mptr = 0;

  function automatic int f_page_next(input int p);
    return (p / PAGE) * PAGE + ((p % PAGE) + 1) % PAGE;
  endfunction

  function automatic int f_lin_next(input int p);
    return (p + 1) % MEM;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  // one clock pulse; returns line level and drive enable while SCL is high
  task automatic clock_bit(input bit v, output bit s, output bit oe);
    sda_m = v;
    wq();
    scl_m = 1'b1;
    wq();
    s  = sda_line;
    oe = sda_oe;
    wq();
    scl_m = 1'b0;
    wq();
  endtask

  task automatic bus_start();
    sda_m = 1'b1;
    wq();
    scl_m = 1'b1;
    wq();
    sda_m = 1'b0;
    wq();
    scl_m = 1'b0;
    wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0;
    wq();
    scl_m = 1'b1;
    wq();
    sda_m = 1'b1;
    wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    bit s, oe;
    for (int i = 7; i >= 0; i--) clock_bit(b[i], s, oe);
    clock_bit(1'b1, s, oe);
    acked = !s;
  endtask

  task automatic recv_byte(input bit ack_it, output logic [7:0] d, output bit oe_ack);
    bit s, oe;
    for (int i = 7; i >= 0; i--) begin
      clock_bit(1'b1, s, oe);
      d[i] = s;
    end
    clock_bit(!ack_it, s, oe_ack);
  endtask

  task automatic write_frame(input int addr, input int n, input int fixedv);
    bit a;
    logic [7:0] d;
    bus_start();
    send_byte({4'b1010, sel, 1'b0}, a);
    chk(a, "R1 write control ack", int'(a), 1);
    send_byte(8'(addr), a);
    chk(a, "R3 address ack", int'(a), 1);
    mptr = addr;
    for (int k = 0; k < n; k++) begin
      d = (fixedv < 0) ? 8'($urandom) : 8'(fixedv);
      send_byte(d, a);
      chk(a, "R4 data ack", int'(a), 1);
      model[mptr] = d;
      mptr = f_page_next(mptr);
    end
    bus_stop();
  endtask

  task automatic do_reads(input int n, input string tag);
    logic [7:0] d;
    bit oe;
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, d, oe);
      chk(d == model[mptr], tag, int'(d), int'(model[mptr]));
      chk(!oe, "R8 released in master ack slot", int'(oe), 0);
      mptr = f_lin_next(mptr);
    end
  endtask

  task automatic random_read(input int addr, input int n);
    bit a;
    bus_start();
    send_byte({4'b1010, sel, 1'b0}, a);
    chk(a, "R6 dummy write control ack", int'(a), 1);
    send_byte(8'(addr), a);
    chk(a, "R6 dummy address ack", int'(a), 1);
    mptr = addr;
    bus_start();
    send_byte({4'b1010, sel, 1'b1}, a);
    chk(a, "R1 read control ack", int'(a), 1);
    do_reads(n, "R6/R7 random sequential read data");
    bus_stop();
  endtask

  task automatic current_read(input int n);
    bit a;
    bus_start();
    send_byte({4'b1010, sel, 1'b1}, a);
    chk(a, "R1 read control ack", int'(a), 1);
    do_reads(n, "R5 current address read data");
    bus_stop();
  endtask

  task automatic foreign_frame(input logic [7:0] ctrl, input string tag);
    bit a;
    bus_start();
    send_byte(ctrl, a);
    chk(!a, tag, int'(a), 0);
    send_byte(8'h10, a);
    chk(!a, "R2 address byte ignored", int'(a), 0);
    send_byte(8'h5A, a);
    chk(!a, "R2 data byte ignored", int'(a), 0);
    bus_stop();
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    finish_run();
  end

  initial begin
    bit a, s, oe;
    logic [7:0] d;
    int addr, n;
    void'($urandom(32'h5EED_1234));
    repeat (4) @(posedge clk);
    #1;
    chk(!sda_oe, "R10 released during reset", int'(sda_oe), 0);
    rst_n = 1'b1;
    wq();
    chk(!sda_oe, "R10 released after reset", int'(sda_oe), 0);

    // fill the whole array with page writes
    for (int pg = 0; pg < MEM / PAGE; pg++) write_frame(pg * PAGE, PAGE, -1);

    // single byte write then random read
    write_frame(5, 1, 8'hA5);
    random_read(5, 1);

    // page write that runs past the page end wraps to the page start (R4)
    write_frame(2 * PAGE + PAGE - 3, 6, -1);
    random_read(2 * PAGE, PAGE);

    // read across the end of memory, then continue without an address (R5)
    random_read(MEM - 2, 4);
    current_read(2);

    // foreign control bytes are ignored (R2)
    foreign_frame({4'b1011, sel, 1'b0}, "R2 wrong device code nack");
    foreign_frame({4'b1010, sel ^ 3'b001, 1'b0}, "R2 wrong select nack");
    random_read(8'h10, 1);

    // out-of-range address (R3): not acknowledged, pointer kept
    bus_start();
    send_byte({4'b1010, sel, 1'b0}, a);
    chk(a, "R1 write control ack", int'(a), 1);
    send_byte(8'(MEM), a);
    chk(!a, "R3 out-of-range address nack", int'(a), 0);
    send_byte(8'h77, a);
    chk(!a, "R3 data after bad address ignored", int'(a), 0);
    bus_stop();
    current_read(1);

    // start in the middle of a data byte aborts it (R9)
    bus_start();
    send_byte({4'b1010, sel, 1'b0}, a);
    send_byte(8'h20, a);
    mptr = 8'h20;
    for (int i = 0; i < 4; i++) clock_bit(i[0], s, oe);
    bus_start();
    send_byte({4'b1010, sel, 1'b1}, a);
    chk(a, "R9 read control ack after mid-byte start", int'(a), 1);
    do_reads(1, "R9 mid-byte start leaves memory and pointer");
    bus_stop();

    // after a master NACK the line stays released (R7)
    bus_start();
    send_byte({4'b1010, sel, 1'b1}, a);
    do_reads(1, "R7 single read before nack");
    for (int i = 0; i < 8; i++) begin
      clock_bit(1'b1, s, oe);
      chk(s && !oe, "R7 released after master nack", int'(oe), 0);
    end
    bus_stop();

    // constrained random frames
    for (int it = 0; it < 10; it++) begin
      addr = int'($urandom % MEM);
      n = 1 + int'($urandom % 12);
      write_frame(addr, n, -1);
      if ($urandom % 2 == 0) current_read(1 + int'($urandom % 4));
      random_read(int'($urandom % MEM), 1 + int'($urandom % 12));
    end

    chk(!sda_oe, "R9 released after final stop", int'(sda_oe), 0);
    finish_run();
  end

endmodule